// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the column address of every beat in that burst. A request gives a starting column, a three-bit burst-length code and an ordering bit. The block then produces one column per clock cycle, with a valid strobe and a flag on the final beat. Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns whose size equals the burst length. The order inside that group is either counting upward with wrap, or the start column XOR the beat index. A full-page burst counts upward across the whole row, wraps past the top column, and runs until a terminate input ends it.

The block sits between a memory controller's command sequencer and its column-address pins. The sequencer pulses `start_i` with the parameters of the access and uses `col_o` while `col_vld_o` is high. The next burst may be launched in the cycle that carries the final beat, so bursts can follow each other with no gap. Command issue, bank and row handling, and read-latency alignment are handled elsewhere.

Top module: `sdram_burst_colgen`

## Requirements
- R1: `blen_code_i` is decoded as 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page. Full page is accepted only when `interleave_i` = 0 (upward order).
- R2: During a fixed burst of length L, every column bit at position log2(L) or above equals the same bit of the start column on every beat.
- R3: With `interleave_i` = 0 and a fixed length L, the low log2(L) bits of beat i equal (start + i) mod L.
- R4: With `interleave_i` = 1 and a fixed length L, the low log2(L) bits of beat i equal start XOR i.
- R5: In a full-page burst, beat i is (start + i) mod 2^COL_W, so the column wraps from the top column of the row to 0.
- R6: A full-page burst ends only on `terminate_i`. If `terminate_i` is high at the rising edge that ends a non-final beat, the next beat is the last one. `terminate_i` has no effect on fixed bursts. A full-page burst always has at least two beats.
- R7: A `start_i` accepted at a rising edge makes beat 0 (the start column) appear in the following cycle with `col_vld_o` high. Each later beat follows one cycle after the one before, with no gap.
- R8: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `interleave_i` = 1, are reserved. An accepted start with such a code raises `err_o` for exactly one cycle and starts no burst.
- R9: `last_o` is high only on the final beat: beat L-1 of a fixed burst, or the terminated beat of a full-page burst. In the cycle after the final beat, `col_vld_o` is low unless a new burst was accepted.
- R10: `start_i` is ignored while the current beat is not the final one. It is accepted when the block is idle and in the final-beat cycle, which makes bursts run back to back.
- R11: After a synchronous reset, `col_vld_o`, `last_o`, `err_o` and `col_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request pulse |
| start_col_i | input | COL_W | Starting column of the burst |
| blen_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 1 = XOR order, 0 = upward order |
| terminate_i | input | 1 | Ends a full-page burst |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | The current beat is the final beat |
| err_o | output | 1 | One-cycle pulse for a rejected reserved code |

## Verification
Three situations are hard to reach from the ports. The first is a start request that arrives in the middle of a burst, which must be ignored. The second is a request that arrives exactly in the final-beat cycle, which must be taken with no gap. The third is a full-page burst that crosses the top column of the row. The stimulus reaches each one with directed sequences: a second `start_i` is driven with conflicting parameters in the middle of an eight-beat burst, a new request is timed onto the `last_o` cycle, and full-page bursts start a few columns below the top with `terminate_i` raised after a chosen number of beats. Every start offset is then swept for each length and both orders. Random starts and random full-page lengths are mixed in, all checked against bench functions.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  // Burst-length codes; the values are decoded by colgen_len_decode.
  typedef enum logic [2:0] {
    BLC_ONE   = 3'b000,
    BLC_TWO   = 3'b001,
    BLC_FOUR  = 3'b010,
    BLC_EIGHT = 3'b011,
    BLC_PAGE  = 3'b111
  } blen_code_e;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned MAX_FIXED_LOG2 = 3;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              ilv_i,
  output logic              valid_o,
  output logic              page_o,
  output logic [COL_W-1:0]  mask_o
);
  // mask_o selects the column bits that move during a burst
  always_comb begin
    valid_o = 1'b1;
    page_o  = 1'b0;
    mask_o  = '0;
    case (code_i)
      BLC_ONE:   mask_o = '0;
      BLC_TWO:   mask_o = COL_W'(1);
      BLC_FOUR:  mask_o = COL_W'(3);
      BLC_EIGHT: mask_o = COL_W'(7);
      BLC_PAGE: begin
        // full page exists only for the upward order
        valid_o = !ilv_i;
        page_o  = !ilv_i;
        mask_o  = '1;
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             ilv_i,
  input  logic             term_i,
  input  logic             dec_valid_i,
  input  logic             dec_page_i,
  input  logic [COL_W-1:0] dec_mask_i,
  output logic             act_o,
  output logic             last_o,
  output logic             err_o,
  output logic             page_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic             nxt_ilv_o,
  output logic [COL_W-1:0] nxt_mask_o,
  output logic [COL_W-1:0] nxt_base_o,
  output logic [COL_W-1:0] nxt_cnt_o
);
  logic             act_q, last_q, err_q, page_q, ilv_q;
  logic [COL_W-1:0] mask_q, base_q, cnt_q;
  logic             act_d, last_d, err_d, page_d, ilv_d;
  logic [COL_W-1:0] mask_d, base_d, cnt_d, cnt_inc;
  logic             accept, launch, running;

  assign cnt_inc = cnt_q + COL_W'(1);
  assign accept  = start_i && (!act_q || last_q);
  assign launch  = accept && dec_valid_i;
  assign running = act_q && !last_q;

  always_comb begin
    act_d  = 1'b0;
    last_d = 1'b0;
    err_d  = accept && !dec_valid_i;
    page_d = page_q;
    ilv_d  = ilv_q;
    mask_d = mask_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (launch) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      base_d = start_col_i;
      mask_d = dec_mask_i;
      ilv_d  = ilv_i;
      page_d = dec_page_i;
      last_d = !dec_page_i && (dec_mask_i == '0);
    end else if (running) begin
      act_d  = 1'b1;
      cnt_d  = cnt_inc;
      last_d = page_q ? term_i : (cnt_inc == mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
      mask_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      last_q <= last_d;
      err_q  <= err_d;
      page_q <= page_d;
      ilv_q  <= ilv_d;
      mask_q <= mask_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign act_o      = act_q;
  assign last_o     = last_q;
  assign err_o      = err_q;
  assign page_o     = page_q;
  assign ilv_o      = ilv_q;
  assign mask_o     = mask_q;
  assign base_o     = base_q;
  assign cnt_o      = cnt_q;
  assign nxt_ilv_o  = ilv_d;
  assign nxt_mask_o = mask_d;
  assign nxt_base_o = base_d;
  assign nxt_cnt_o  = cnt_d;

  AST_PAGE_UPWARD_ONLY: assert property (@(posedge clk) disable iff (rst)
    (act_q && page_q) |-> !ilv_q); // R1
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    (act_q && !last_q) |=> act_q); // R7
  AST_BUSY_HOLDS_BASE: assert property (@(posedge clk) disable iff (rst)
    (act_q && !last_q) |=> $stable(base_q)); // R10
  AST_TERM_ENDS_PAGE: assert property (@(posedge clk) disable iff (rst)
    (act_q && !last_q && page_q && term_i) |=> last_q); // R6
  AST_FIXED_IGNORES_TERM: assert property (@(posedge clk) disable iff (rst)
    (act_q && !last_q && !page_q && (cnt_inc != mask_q)) |=> !last_q); // R6
  AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !act_q); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (err_q && !start_i) |=> !err_q); // R8
  AST_LAST_IS_BEAT: assert property (@(posedge clk) disable iff (rst)
    last_q |-> act_q); // R9
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (last_q && !start_i) |=> !act_q); // R9
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + cnt_i;

  // each bit is either frozen, counted or XOR-ordered
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    always_comb begin
      if (!mask_i[b])  col_o[b] = base_i[b];
      else if (ilv_i)  col_o[b] = base_i[b] ^ cnt_i[b];
      else             col_o[b] = sum[b];
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [CODE_W-1:0] blen_code_i,
  input  logic              interleave_i,
  input  logic              terminate_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_vld_o,
  output logic              last_o,
  output logic              err_o
);
  logic             dec_valid, dec_page;
  logic [COL_W-1:0] dec_mask;
  logic             page_q, ilv_q, nxt_ilv;
  logic [COL_W-1:0] mask_q, base_q, cnt_q;
  logic [COL_W-1:0] nxt_mask, nxt_base, nxt_cnt, nxt_col;
  logic [COL_W-1:0] col_q;

  colgen_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i  (blen_code_i),
    .ilv_i   (interleave_i),
    .valid_o (dec_valid),
    .page_o  (dec_page),
    .mask_o  (dec_mask)
  );

  colgen_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .ilv_i       (interleave_i),
    .term_i      (terminate_i),
    .dec_valid_i (dec_valid),
    .dec_page_i  (dec_page),
    .dec_mask_i  (dec_mask),
    .act_o       (col_vld_o),
    .last_o      (last_o),
    .err_o       (err_o),
    .page_o      (page_q),
    .ilv_o       (ilv_q),
    .mask_o      (mask_q),
    .base_o      (base_q),
    .cnt_o       (cnt_q),
    .nxt_ilv_o   (nxt_ilv),
    .nxt_mask_o  (nxt_mask),
    .nxt_base_o  (nxt_base),
    .nxt_cnt_o   (nxt_cnt)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (nxt_base),
    .cnt_i  (nxt_cnt),
    .mask_i (nxt_mask),
    .ilv_i  (nxt_ilv),
    .col_o  (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) col_q <= '0;
    else     col_q <= nxt_col;
  end
  assign col_o = col_q;

  AST_UPPER_BITS_FIXED: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && !last_o) |=> ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && !last_o && !ilv_q) |=>
      ((col_o & mask_q) == (COL_W'($past(col_o) + COL_W'(1)) & mask_q))); // R3
  AST_XOR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && ilv_q) |-> (((col_o ^ base_q) & mask_q) == (cnt_q & mask_q))); // R4
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (col_vld_o && !last_o && page_q) |=> (col_o == COL_W'($past(col_o) + COL_W'(1)))); // R5
endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;
  localparam int COL_W = 10;
  localparam int PAGE = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst;
  logic             start_i, interleave_i, terminate_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       blen_code_i;
  logic [COL_W-1:0] col_o;
  logic             col_vld_o, last_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) i_sdram_burst_colgen (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_code_i(blen_code_i), .interleave_i(interleave_i),
    .terminate_i(terminate_i), .col_o(col_o), .col_vld_o(col_vld_o),
    .last_o(last_o), .err_o(err_o)
  );

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 0;
    endcase
  endfunction

  // len 0 means full page
  function automatic logic [COL_W-1:0] exp_col(input int start, input int len,
                                               input bit ilv, input int i);
    int msk, lo;
    if (len == 0) return COL_W'((start + i) % PAGE);
    msk = len - 1;
    lo  = ilv ? ((start ^ i) & msk) : ((start + i) & msk);
    return COL_W'((start & ~msk) | lo);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input int start, input logic [2:0] code, input bit ilv);
    start_i      = 1'b1;
    start_col_i  = COL_W'(start);
    blen_code_i  = code;
    interleave_i = ilv;
  endtask

  // fixed burst: R2 R3 R4 R7 R9
  task automatic run_fixed(input int start, input logic [2:0] code, input bit ilv);
    int len;
    len = len_of(code);
    @(negedge clk);
    request(start, code, ilv);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < len; i++) begin
      check("R7 valid", col_vld_o, 1);
      check(ilv ? "R4 column" : "R3 column", col_o, exp_col(start, len, ilv, i));
      check("R9 last", last_o, (i == len - 1));
      if (i < len - 1) @(negedge clk);
    end
    @(negedge clk);
    check("R9 idle after last", col_vld_o, 0);
  endtask

  // full page of nbeats (>=2): R5 R6
  task automatic run_page(input int start, input int nbeats);
    @(negedge clk);
    request(start, 3'b111, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < nbeats; i++) begin
      check("R7 valid", col_vld_o, 1);
      check("R5 page column", col_o, exp_col(start, 0, 1'b0, i));
      check("R6 last", last_o, (i == nbeats - 1));
      terminate_i = (i == nbeats - 2);
      if (i < nbeats - 1) @(negedge clk);
    end
    terminate_i = 1'b0;
    @(negedge clk);
    check("R9 idle after page", col_vld_o, 0);
  endtask

  task automatic run_reserved(input logic [2:0] code, input bit ilv);
    @(negedge clk);
    request($urandom % PAGE, code, ilv);
    @(negedge clk);
    start_i = 1'b0;
    check("R8 err pulse", err_o, 1);
    check("R8 no burst", col_vld_o, 0);
    @(negedge clk);
    check("R8 err one cycle", err_o, 0);
    check("R8 still idle", col_vld_o, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; start_i = 1'b0; start_col_i = '0; blen_code_i = '0;
    interleave_i = 1'b0; terminate_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 vld", col_vld_o, 0);
    check("R11 last", last_o, 0);
    check("R11 err", err_o, 0);
    check("R11 col", col_o, 0);

    // R1 R2 R3 R4: every offset, length and order
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++)
        for (int off = 0; off < 8; off++)
          run_fixed(((($urandom % PAGE) & ~7) | off), 3'(c), t[0]);

    // R5 R6: wrap across top of page
    run_page(PAGE - 3, 7);
    run_page(PAGE - 1, 2);
    run_page(100, 2);

    // R8 reserved codes
    run_reserved(3'b100, 1'b0);
    run_reserved(3'b101, 1'b1);
    run_reserved(3'b110, 1'b0);
    run_reserved(3'b111, 1'b1);

    // R10: start in mid-burst is ignored
    @(negedge clk);
    request(13, 3'b011, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check("R10 col", col_o, exp_col(13, 8, 1'b0, i));
      check("R10 last", last_o, (i == 7));
      if (i == 2) request(600, 3'b001, 1'b1);
      else start_i = 1'b0;
      if (i < 7) @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    check("R10 no extra burst", col_vld_o, 0);

    // R6: terminate ignored in fixed burst
    @(negedge clk);
    request(42, 3'b010, 1'b1);
    terminate_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R6 fixed col", col_o, exp_col(42, 4, 1'b1, i));
      check("R6 fixed last", last_o, (i == 3));
      if (i < 3) @(negedge clk);
    end
    terminate_i = 1'b0;
    @(negedge clk);

    // R10: back to back in final-beat cycle
    @(negedge clk);
    request(301, 3'b001, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    check("R10 b2b first", col_o, exp_col(301, 2, 1'b0, 0));
    @(negedge clk);
    check("R10 b2b last", last_o, 1);
    request(77, 3'b010, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R10 b2b valid", col_vld_o, 1);
      check("R10 b2b col", col_o, exp_col(77, 4, 1'b1, i));
      if (i < 3) @(negedge clk);
    end
    @(negedge clk);

    // random mix
    for (int n = 0; n < 120; n++)
      run_fixed($urandom % PAGE, 3'($urandom % 4), 1'($urandom % 2));
    for (int n = 0; n < 20; n++)
      run_page((n % 2) ? (PAGE - 1 - ($urandom % 8)) : ($urandom % PAGE),
               2 + ($urandom % 40));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule